// File: doc/BRIEF.md
# Multi-Rate Synchronous Square-Wave Generator

The block turns one fast reference clock into four slower square waves that all stay synchronous to that reference. A chain of five modulo counters shares the reference clock. Each counter advances only when the stage before it issues a one-cycle terminal-count pulse. Four of those pulse trains each drive a two-state toggle machine, which turns the narrow pulses into an even-duty square wave and halves the rate once more.

With a 50 MHz reference, the default moduli are 125, 2, 125, 80 and 20. The four outputs then run at 100 kHz, 1.6 kHz, 20 Hz and 1 Hz. The parameter `FAST_SIM` swaps in small moduli (5, 2, 3, 4, 2) so that simulation runs quickly. In that mode every counter keeps the width that the full-rate modulus needs, so the register count stays at 31 in both modes. No output is ever used as a clock inside the block.

Wiring of the chain:
- Stage A counts reference cycles.
- Stage B counts A pulses and toggles `sq_fast`.
- Stage C counts A pulses and toggles `sq_mid`.
- Stage D counts C pulses and toggles `sq_slow`.
- Stage E counts D pulses and toggles `sq_sec`.

Each toggle machine has two states, SQ_LOW and SQ_HIGH. On a tick, the transition RISE moves it from SQ_LOW to SQ_HIGH and the transition FALL moves it from SQ_HIGH to SQ_LOW. Without a tick it stays in its current state (HOLD).

Top module: `multirate_sqgen`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge clears every counter and puts every output low (SQ_LOW) after that edge.
- R2: Let n be the number of rising edges since the last reset edge. After n edges, `sq_fast` equals bit 0 of floor(n / (A·B)).
- R3: After n edges, `sq_mid` equals bit 0 of floor(n / (A·C)).
- R4: After n edges, `sq_slow` equals bit 0 of floor(n / (A·C·D)).
- R5: After n edges, `sq_sec` equals bit 0 of floor(n / (A·C·D·E)).
- R6: Each output is high for exactly half of its own period. Over any whole number of periods that starts at reset, the count of high cycles equals the count of low cycles.
- R7: At every multiple of the `sq_sec` period after reset, all four outputs are low together. A counter holds its value in any cycle in which its enable is low, and no terminal-count pulse lasts longer than one cycle.
- R8: With `FAST_SIM`=0 the moduli are A=125, B=2, C=125, D=80, E=20. `sq_fast` toggles every 250 edges and `sq_mid` toggles every 15625 edges. With `FAST_SIM`=1 they are A=5, B=2, C=3, D=4, E=2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; every flop in the block uses it |
| rst | input | 1 | Synchronous reset, active high |
| sq_fast | output | 1 | Square wave at reference / (2·A·B) |
| sq_mid | output | 1 | Square wave at reference / (2·A·C) |
| sq_slow | output | 1 | Square wave at reference / (2·A·C·D) |
| sq_sec | output | 1 | Square wave at reference / (2·A·C·D·E) |

## Verification
An output changes at the very edge that closes the cycle in which its stage shows the final count. So after n edges since reset, every output equals a known bit of n divided by its stage product, with no added latency. The bench keeps its own edge counter, which it clears on every edge where it drove reset high. It samples all outputs on the falling edge, half a cycle after the change is due, and compares them with that formula. Reset is driven only on falling edges, so the expected value never depends on process order at the rising edge.

// File: rtl/multirate_sqgen_pkg.sv
package multirate_sqgen_pkg;

    typedef enum logic {
        SQ_LOW  = 1'b0,
        SQ_HIGH = 1'b1
    } sq_state_t;

    localparam int NUM_STAGES = 5;
    localparam int NUM_OUTS   = 4;

    // Full-rate moduli in stage order A..E
    localparam int FULL_A = 125;
    localparam int FULL_B = 2;
    localparam int FULL_C = 125;
    localparam int FULL_D = 80;
    localparam int FULL_E = 20;

    // Shortened moduli used when simulating
    localparam int SIM_A = 5;
    localparam int SIM_B = 2;
    localparam int SIM_C = 3;
    localparam int SIM_D = 4;
    localparam int SIM_E = 2;

    function automatic int pick_mod(input bit fast, input int full_m, input int sim_m);
        return fast ? sim_m : full_m;
    endfunction

    function automatic int cnt_width(input int full_m);
        return (full_m < 2) ? 1 : $clog2(full_m);
    endfunction

endpackage

// File: rtl/multirate_sqgen_stage.sv
module multirate_sqgen_stage #(
    parameter int MODULUS = 125,
    parameter int WIDTH   = 7
) (
    input  logic clk_ref,
    input  logic rst,
    input  logic en,
    output logic tc
);

    localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_d;
    logic             at_last;

    always_comb begin
        at_last = (cnt_q == LAST);
        tc      = en && at_last;
        if (tc) begin
            cnt_d = '0;
        end else if (en) begin
            cnt_d = cnt_q + WIDTH'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk_ref) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R7: count never leaves 0..MODULUS-1
    p_count_in_range_r7: assert property (@(posedge clk_ref) disable iff (rst)
        cnt_q <= LAST);

    // R7: an idle stage keeps its count
    p_hold_when_idle_r7: assert property (@(posedge clk_ref) disable iff (rst)
        !en |=> $stable(cnt_q));

    // R7: terminal-count pulse lasts one cycle
    p_tc_single_r7: assert property (@(posedge clk_ref) disable iff (rst)
        tc |=> !tc);

endmodule

// File: rtl/multirate_sqgen_square.sv
module multirate_sqgen_square
    import multirate_sqgen_pkg::*;
(
    input  logic clk_ref,
    input  logic rst,
    input  logic tick,
    output logic sq
);

    sq_state_t state_q;
    sq_state_t state_d;

    // State register
    always_ff @(posedge clk_ref) begin
        if (rst) begin
            state_q <= SQ_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: RISE, FALL or HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_LOW:  if (tick) state_d = SQ_HIGH;
            SQ_HIGH: if (tick) state_d = SQ_LOW;
            default: state_d = SQ_LOW;
        endcase
    end

    // Output
    always_comb begin
        sq = (state_q == SQ_HIGH);
    end

    // R6: a tick always flips the output
    p_flip_on_tick_r6: assert property (@(posedge clk_ref) disable iff (rst)
        tick |=> (sq != $past(sq)));

    // R6: without a tick the output holds
    p_hold_no_tick_r6: assert property (@(posedge clk_ref) disable iff (rst)
        !tick |=> $stable(sq));

endmodule

// File: rtl/multirate_sqgen.sv
module multirate_sqgen
    import multirate_sqgen_pkg::*;
#(
    parameter bit FAST_SIM = 1'b0
) (
    input  logic clk_ref,
    input  logic rst,
    output logic sq_fast,
    output logic sq_mid,
    output logic sq_slow,
    output logic sq_sec
);

    localparam int MOD_A = pick_mod(FAST_SIM, FULL_A, SIM_A);
    localparam int MOD_B = pick_mod(FAST_SIM, FULL_B, SIM_B);
    localparam int MOD_C = pick_mod(FAST_SIM, FULL_C, SIM_C);
    localparam int MOD_D = pick_mod(FAST_SIM, FULL_D, SIM_D);
    localparam int MOD_E = pick_mod(FAST_SIM, FULL_E, SIM_E);

    // Widths fixed by full-rate moduli so both modes keep 31 flops
    localparam int W_A = cnt_width(FULL_A);
    localparam int W_B = cnt_width(FULL_B);
    localparam int W_C = cnt_width(FULL_C);
    localparam int W_D = cnt_width(FULL_D);
    localparam int W_E = cnt_width(FULL_E);

    logic tc_a;
    logic [NUM_OUTS-1:0] tick;
    logic [NUM_OUTS-1:0] sq;

    multirate_sqgen_stage #(.MODULUS(MOD_A), .WIDTH(W_A)) u_stage_a (
        .clk_ref(clk_ref), .rst(rst), .en(1'b1), .tc(tc_a));

    multirate_sqgen_stage #(.MODULUS(MOD_B), .WIDTH(W_B)) u_stage_b (
        .clk_ref(clk_ref), .rst(rst), .en(tc_a), .tc(tick[0]));

    multirate_sqgen_stage #(.MODULUS(MOD_C), .WIDTH(W_C)) u_stage_c (
        .clk_ref(clk_ref), .rst(rst), .en(tc_a), .tc(tick[1]));

    multirate_sqgen_stage #(.MODULUS(MOD_D), .WIDTH(W_D)) u_stage_d (
        .clk_ref(clk_ref), .rst(rst), .en(tick[1]), .tc(tick[2]));

    multirate_sqgen_stage #(.MODULUS(MOD_E), .WIDTH(W_E)) u_stage_e (
        .clk_ref(clk_ref), .rst(rst), .en(tick[2]), .tc(tick[3]));

    for (genvar g = 0; g < NUM_OUTS; g++) begin : g_square
        multirate_sqgen_square u_square (
            .clk_ref(clk_ref),
            .rst    (rst),
            .tick   (tick[g]),
            .sq     (sq[g])
        );
    end

    always_comb begin
        sq_fast = sq[0];
        sq_mid  = sq[1];
        sq_slow = sq[2];
        sq_sec  = sq[3];
    end

    // R1: reset leaves every output low
    p_reset_low_r1: assert property (@(posedge clk_ref)
        rst |=> (sq == '0));

    // R7: the slowest output only moves when the fastest stage pulses too
    p_sec_moves_with_fast_r7: assert property (@(posedge clk_ref) disable iff (rst)
        tick[3] |-> tick[2] && tick[1] && tc_a);

    // R6: at most all four flip in one cycle, slower ones only with faster ticks
    p_tick_nesting_r6: assert property (@(posedge clk_ref) disable iff (rst)
        tick[2] |-> tick[1]);

endmodule

// File: tb/multirate_sqgen_bench.sv
module multirate_sqgen_bench;

    localparam int CLK_PERIOD = 20;
    localparam int A = 5, B = 2, C = 3, D = 4, E = 2;
    localparam int FA = 125, FB = 2, FC = 125;
    localparam int MAX_CYCLES = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_full = 1'b1;
    logic o_fast, o_mid, o_slow, o_sec;
    logic f_fast, f_mid, f_slow, f_sec;

    int n_edges = 0;
    int n_full = 0;
    bit rst_seen = 1'b1;
    bit started = 1'b0;
    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    multirate_sqgen #(.FAST_SIM(1'b1)) u_multirate_sqgen (
        .clk_ref(clk), .rst(rst),
        .sq_fast(o_fast), .sq_mid(o_mid), .sq_slow(o_slow), .sq_sec(o_sec));

    multirate_sqgen #(.FAST_SIM(1'b0)) u_multirate_sqgen_full (
        .clk_ref(clk), .rst(rst_full),
        .sq_fast(f_fast), .sq_mid(f_mid), .sq_slow(f_slow), .sq_sec(f_sec));

    function automatic logic exp_sq(input int n, input int half);
        return logic'((n / half) % 2);
    endfunction

    always @(posedge clk) begin
        cycles   <= cycles + 1;
        started  <= 1'b1;
        rst_seen <= rst;
        n_edges  <= rst ? 0 : n_edges + 1;
        n_full   <= rst_full ? 0 : n_full + 1;
    end

    task automatic chk(input string req, input logic got, input logic exp, input int n);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s at n=%0d: got %0b expected %0b", req, n, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            if (rst_seen) begin
                chk("R1 all-low", |{o_fast, o_mid, o_slow, o_sec}, 1'b0, n_edges);
            end
            chk("R2 sq_fast", o_fast, exp_sq(n_edges, A*B), n_edges);
            chk("R3 sq_mid", o_mid, exp_sq(n_edges, A*C), n_edges);
            chk("R4 sq_slow", o_slow, exp_sq(n_edges, A*C*D), n_edges);
            chk("R5 sq_sec", o_sec, exp_sq(n_edges, A*C*D*E), n_edges);
            if (n_edges > 0 && (n_edges % (2*A*C*D*E)) == 0) begin
                chk("R7 common-low", |{o_fast, o_mid, o_slow, o_sec}, 1'b0, n_edges);
            end
            chk("R8 full sq_fast", f_fast, exp_sq(n_full, FA*FB), n_full);
            chk("R8 full sq_mid", f_mid, exp_sq(n_full, FA*FC), n_full);
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int hi_cnt[4];
        int win;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rst_full = 1'b0;
        // Directed: duty over two sq_sec periods from reset (R6)
        win = 2 * (2*A*C*D*E);
        for (int k = 0; k < 4; k++) hi_cnt[k] = 0;
        for (int i = 0; i < win; i++) begin
            hi_cnt[0] += int'(o_fast);
            hi_cnt[1] += int'(o_mid);
            hi_cnt[2] += int'(o_slow);
            hi_cnt[3] += int'(o_sec);
            @(negedge clk);
        end
        for (int k = 0; k < 4; k++) begin
            checks++;
            if (hi_cnt[k] != win/2) begin
                fails++;
                $display("FAIL R6 duty out%0d: got %0d expected %0d", k, hi_cnt[k], win/2);
            end
        end
        // Directed: one-cycle reset right after a toggle edge (R1)
        repeat (A*B) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        // Random segments with random reset lengths
        for (int s = 0; s < 40; s++) begin
            repeat (50 + ($urandom % 500)) @(negedge clk);
            rst = 1'b1;
            repeat (1 + ($urandom % 3)) @(negedge clk);
            rst = 1'b0;
        end
        // Long unbroken run so the full-rate sq_mid toggles twice (R8)
        while (n_full < 2*FA*FC + 100) @(negedge clk);
        finish_run();
    end

endmodule